// File: doc/BRIEF.md
# Unpacked Floating-Point Adder

This block adds or subtracts two floating-point operands held in unpacked form: a class code, a sign, a signed unbiased exponent and a fixed-point mantissa with two integer bits and sixty-two fraction bits, where weight 1.0 is bit 62. It returns the sum in the same unpacked form, together with a sticky bit that records any nonzero bits lost on alignment or renormalization, and two invalid-operation flags. Rounding to a storage format, packing and trapping are left to the stages that follow.

A controlling state machine accepts one operation through a valid/ready handshake and walks it through the states ST_IDLE, ST_RESOLVE, ST_ALIGN, ST_COMBINE, ST_NORM and ST_HOLD. Transitions: ST_IDLE goes to ST_RESOLVE when in_valid is high. ST_RESOLVE goes to ST_HOLD when the ordered pair is a special case (any NaN, infinity or zero operand), otherwise to ST_ALIGN. ST_ALIGN always goes to ST_COMBINE, ST_COMBINE always goes to ST_NORM, ST_NORM always goes to ST_HOLD. ST_HOLD goes back to ST_IDLE when out_ready is high. Subtraction reuses the add path with the second operand's sign inverted; an opposite-sign pair is always computed as x minus y and, when the borrow shows that the magnitudes were the wrong way round, the difference is negated rather than compared first.

Top module: `fpadd_unit`

## Requirements
- R1: With op_sub = 1 the sign of operand b is inverted before any other step, for every class, including NaN and infinity; with op_sub = 0 both operands are used as given.
- R2: Class codes are zero = 0, number = 1, infinity = 2, quiet NaN = 3, signalling NaN = 4. The operand with the larger code becomes y and the other x; on equal codes a is x and b is y.
- R3: If y is a quiet or signalling NaN, the result is y unchanged (class, sign, exponent, mantissa), sticky 0, and flag_nan_in = 1.
- R4: If y is infinity and x is infinity of the opposite sign, the result is the default NaN (class 3, sign 0, exponent 0, mantissa 0x6000000000000000) with flag_inf_diff = 1; any other case with y infinite returns y.
- R5: If both operands are zero the result is y with sign (x sign AND y sign), except for rnd_mode = 3 (toward minus infinity), where the sign is (x sign OR y sign). If only x is zero, the result is y. Sticky is 0 for all such results.
- R6: For two numbers, the one with the larger exponent becomes x; y's mantissa is shifted right by the exponent difference and every bit shifted out is ORed into sticky; differences of 64 or more leave a zero mantissa and a sticky equal to the OR of all of y's bits. Equal exponents give sticky 0. The result exponent starts as x's.
- R7: With equal signs the mantissas are added; a sum of 2.0 or more (bit 63 set) is shifted right by one, its lost bit ORed into sticky, and the exponent incremented.
- R8: With opposite signs the result is x minus y minus sticky, signed as x; if bit 63 of the difference is set, the mantissa is two's-complement negated and y's sign is used.
- R9: A difference of exactly zero yields class zero, exponent 0, mantissa 0, sticky 0, and a negative sign only when rnd_mode = 3.
- R10: Every result of class number produced by the arithmetic path has a mantissa in [1.0, 2.0): bit 62 set and bit 63 clear, with the exponent reduced by one for each left shift.
- R11: in_ready is high only in ST_IDLE; after reset in_ready = 1 and out_valid = 0; the result and flags stay stable while out_valid is high and out_ready is low, and out_valid falls one cycle after out_ready is seen high.
- R12: out_valid rises 2 cycles after the accepting edge for special cases and 5 cycles after it when both operands are numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit can accept operands |
| op_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| rnd_mode | input | 2 | Rounding mode; 3 = toward minus infinity |
| a_class | input | 3 | Class code of a |
| a_sign | input | 1 | Sign of a |
| a_exp | input | 16 | Signed exponent of a |
| a_mant | input | 64 | Mantissa of a, weight 1.0 at bit 62 |
| b_class | input | 3 | Class code of b |
| b_sign | input | 1 | Sign of b |
| b_exp | input | 16 | Signed exponent of b |
| b_mant | input | 64 | Mantissa of b |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_class | output | 3 | Class code of result |
| res_sign | output | 1 | Sign of result |
| res_exp | output | 16 | Signed exponent of result |
| res_mant | output | 64 | Mantissa of result |
| res_sticky | output | 1 | OR of all bits lost below the mantissa |
| flag_nan_in | output | 1 | A NaN operand was propagated |
| flag_inf_diff | output | 1 | Infinities of opposite sign were combined |

## Verification
The accepting edge is the rising edge at which in_valid meets in_ready; special cases leave ST_RESOLVE for ST_HOLD on the next edge, so out_valid is due two cycles later, while a pair of numbers passes through alignment, combining and normalization and is due five cycles later. The bench drives and samples on falling edges, counts falling edges from the accept until out_valid is seen, and compares that count with 2 or 5 before comparing every result field against its own model. Holding out_ready low on some transactions shows the result is frozen for three cycles and that out_valid drops the cycle after release.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_NUM  = 3'd1,
        CL_INF  = 3'd2,
        CL_QNAN = 3'd3,
        CL_SNAN = 3'd4
    } fclass_e;

    typedef enum logic [1:0] {
        RM_NEAR   = 2'd0,
        RM_TOZERO = 2'd1,
        RM_UP     = 2'd2,
        RM_DOWN   = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_ALIGN,
        ST_COMBINE,
        ST_NORM,
        ST_HOLD
    } state_e;

endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
    parameter int W  = 63,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] count
);
    // highest set bit wins because the scan runs upward
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpadd_rshift_sticky.sv
module fpadd_rshift_sticky #(
    parameter int W  = 64,
    parameter int LG = $clog2(W),
    parameter int AW = LG + 1
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout,
    output logic          sticky
);
    logic [W-1:0] stg [LG+1];
    logic         stk [LG+1];
    logic         big;

    assign stg[0] = din;
    assign stk[0] = 1'b0;

    for (genvar i = 0; i < LG; i++) begin : g_stage
        localparam int          SH      = 1 << i;
        localparam logic [W-1:0] LOWMASK = (W'(1) << SH) - W'(1);
        assign stg[i+1] = amt[i] ? (stg[i] >> SH) : stg[i];
        assign stk[i+1] = stk[i] | (amt[i] & (|(stg[i] & LOWMASK)));
    end

    assign big    = (amt >= AW'(W));
    assign dout   = big ? '0 : stg[LG];
    assign sticky = big ? (|din) : stk[LG];
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int INT_W  = 2,
    parameter int FRAC_W = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              op_sub,
    input  logic [1:0]        rnd_mode,
    input  logic [2:0]        a_class,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [INT_W+FRAC_W-1:0] a_mant,
    input  logic [2:0]        b_class,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [INT_W+FRAC_W-1:0] b_mant,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        res_class,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [INT_W+FRAC_W-1:0] res_mant,
    output logic              res_sticky,
    output logic              flag_nan_in,
    output logic              flag_inf_diff
);
    localparam int MANT_W = INT_W + FRAC_W;
    localparam int SH_W   = $clog2(MANT_W) + 1;
    localparam int LZ_W   = $clog2(MANT_W);
    localparam logic [MANT_W-1:0] ONE  = MANT_W'(1) << FRAC_W;
    localparam logic [MANT_W-1:0] DNAN = ONE | (ONE >> 1);
    localparam logic signed [EXP_W:0] MW_S = (EXP_W+1)'(MANT_W);

    state_e state, state_nx;

    logic [2:0]               x_cls, y_cls, r_cls;
    logic                     x_sgn, y_sgn, r_sgn;
    logic signed [EXP_W-1:0]  x_exp, y_exp, r_exp;
    logic [MANT_W-1:0]        x_man, y_man, r_man;
    logic                     stk_q, r_stk, f_nan, f_inf;
    logic [1:0]               rm_q;

    logic b_sgn_eff;
    logic y_nan, y_inf, y_zero, x_zero, special;
    logic signed [EXP_W:0]    ediff;
    logic [SH_W-1:0]          sh_amt;
    logic [MANT_W-1:0]        sh_out, sum_w, dif_w;
    logic                     sh_stk;
    logic [LZ_W-1:0]          lz;

    assign b_sgn_eff = b_sign ^ op_sub;

    assign y_nan   = (y_cls == CL_QNAN) || (y_cls == CL_SNAN);
    assign y_inf   = (y_cls == CL_INF);
    assign y_zero  = (y_cls == CL_ZERO);
    assign x_zero  = (x_cls == CL_ZERO);
    assign special = y_nan || y_inf || y_zero || x_zero;

    assign ediff  = {x_exp[EXP_W-1], x_exp} - {y_exp[EXP_W-1], y_exp};
    assign sh_amt = (ediff >= MW_S) ? SH_W'(MANT_W) : ediff[SH_W-1:0];

    fpadd_rshift_sticky #(.W(MANT_W)) u_align (
        .din    (y_man),
        .amt    (sh_amt),
        .dout   (sh_out),
        .sticky (sh_stk)
    );

    assign sum_w = x_man + y_man;
    assign dif_w = x_man - y_man - MANT_W'(stk_q);

    fpadd_lzc #(.W(MANT_W-1)) u_lzc (
        .din   (r_man[MANT_W-2:0]),
        .count (lz)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (in_valid) state_nx = ST_RESOLVE;
            ST_RESOLVE: state_nx = special ? ST_HOLD : ST_ALIGN;
            ST_ALIGN:   state_nx = ST_COMBINE;
            ST_COMBINE: state_nx = ST_NORM;
            ST_NORM:    state_nx = ST_HOLD;
            ST_HOLD:    if (out_ready) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_HOLD);
    end

    assign res_class     = r_cls;
    assign res_sign      = r_sgn;
    assign res_exp       = r_exp;
    assign res_mant      = r_man;
    assign res_sticky    = r_stk;
    assign flag_nan_in   = f_nan;
    assign flag_inf_diff = f_inf;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_cls <= '0; x_sgn <= 1'b0; x_exp <= '0; x_man <= '0;
            y_cls <= '0; y_sgn <= 1'b0; y_exp <= '0; y_man <= '0;
            r_cls <= '0; r_sgn <= 1'b0; r_exp <= '0; r_man <= '0;
            r_stk <= 1'b0; stk_q <= 1'b0; f_nan <= 1'b0; f_inf <= 1'b0;
            rm_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    f_nan <= 1'b0;
                    f_inf <= 1'b0;
                    stk_q <= 1'b0;
                    rm_q  <= rnd_mode;
                    if (a_class > b_class) begin
                        x_cls <= b_class; x_sgn <= b_sgn_eff; x_exp <= b_exp; x_man <= b_mant;
                        y_cls <= a_class; y_sgn <= a_sign;    y_exp <= a_exp; y_man <= a_mant;
                    end else begin
                        x_cls <= a_class; x_sgn <= a_sign;    x_exp <= a_exp; x_man <= a_mant;
                        y_cls <= b_class; y_sgn <= b_sgn_eff; y_exp <= b_exp; y_man <= b_mant;
                    end
                end
                ST_RESOLVE: begin
                    r_stk <= 1'b0;
                    if (special) begin
                        r_cls <= y_cls; r_sgn <= y_sgn; r_exp <= y_exp; r_man <= y_man;
                        if (y_nan) begin
                            f_nan <= 1'b1;
                        end else if (y_inf) begin
                            if (x_cls == CL_INF && x_sgn != y_sgn) begin
                                f_inf <= 1'b1;
                                r_cls <= CL_QNAN; r_sgn <= 1'b0; r_exp <= '0; r_man <= DNAN;
                            end
                        end else if (y_zero) begin
                            r_sgn <= (rm_q == RM_DOWN) ? (x_sgn | y_sgn) : (x_sgn & y_sgn);
                        end
                    end else if (x_exp < y_exp) begin
                        x_cls <= y_cls; x_sgn <= y_sgn; x_exp <= y_exp; x_man <= y_man;
                        y_cls <= x_cls; y_sgn <= x_sgn; y_exp <= x_exp; y_man <= x_man;
                    end
                end
                ST_ALIGN: begin
                    y_man <= sh_out;
                    stk_q <= sh_stk;
                end
                ST_COMBINE: begin
                    if (x_sgn == y_sgn) begin
                        r_cls <= CL_NUM;
                        r_sgn <= x_sgn;
                        if (sum_w[MANT_W-1]) begin
                            r_man <= sum_w >> 1;
                            r_exp <= x_exp + EXP_W'(1);
                            r_stk <= stk_q | sum_w[0];
                        end else begin
                            r_man <= sum_w;
                            r_exp <= x_exp;
                            r_stk <= stk_q;
                        end
                    end else if (dif_w == '0) begin
                        r_cls <= CL_ZERO;
                        r_sgn <= (rm_q == RM_DOWN);
                        r_exp <= '0;
                        r_man <= '0;
                        r_stk <= 1'b0;
                    end else begin
                        r_cls <= CL_NUM;
                        r_exp <= x_exp;
                        r_stk <= stk_q;
                        if (dif_w[MANT_W-1]) begin
                            r_man <= -dif_w;
                            r_sgn <= y_sgn;
                        end else begin
                            r_man <= dif_w;
                            r_sgn <= x_sgn;
                        end
                    end
                end
                ST_NORM: begin
                    if (r_cls == CL_NUM && !r_man[FRAC_W]) begin
                        r_man <= r_man << lz;
                        r_exp <= r_exp - EXP_W'(lz);
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    // R11: result frozen while the consumer stalls
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({res_class, res_sign, res_exp,
                                       res_mant, res_sticky, flag_nan_in, flag_inf_diff})));

    // R11: an accepted operation closes the input side
    a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R10: numbers leave normalized
    a_r10_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_class == CL_NUM && $past(state) == ST_NORM)
            |-> (res_mant[FRAC_W] && !res_mant[MANT_W-1]));

    // R3: the NaN flag only accompanies a NaN result
    a_r3_nan_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_nan_in) |-> (res_class == CL_QNAN || res_class == CL_SNAN) && !flag_inf_diff);

    // R4: opposite infinities give the default NaN
    a_r4_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_inf_diff) |-> (res_class == CL_QNAN && res_mant == DNAN && !res_sign));

    // R9: zero results carry no sticky
    a_r9_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_class == CL_ZERO) |-> !res_sticky);

endmodule

// File: tb/fpadd_unit_tb_top.sv
module fpadd_unit_tb_top;

    typedef struct packed {
        logic [2:0]  c;
        logic        s;
        logic [15:0] e;
        logic [63:0] m;
        logic        k;
        logic        fn;
        logic        fi;
    } res_t;

    localparam logic [63:0] ONE  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'h6000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, op_sub = 1'b0, out_ready = 1'b1;
    logic [1:0]  rnd_mode = '0;
    logic [2:0]  a_class = '0, b_class = '0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [15:0] a_exp = '0, b_exp = '0;
    logic [63:0] a_mant = '0, b_mant = '0;
    logic        in_ready, out_valid;
    logic [2:0]  res_class;
    logic        res_sign, res_sticky, flag_nan_in, flag_inf_diff;
    logic [15:0] res_exp;
    logic [63:0] res_mant;
    logic [86:0] got;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fpadd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sub(op_sub), .rnd_mode(rnd_mode),
        .a_class(a_class), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_class(b_class), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .out_valid(out_valid), .out_ready(out_ready),
        .res_class(res_class), .res_sign(res_sign), .res_exp(res_exp),
        .res_mant(res_mant), .res_sticky(res_sticky),
        .flag_nan_in(flag_nan_in), .flag_inf_diff(flag_inf_diff)
    );

    assign got = {res_class, res_sign, res_exp, res_mant, res_sticky, flag_nan_in, flag_inf_diff};

    task automatic chk(input string tag, input bit ok, input logic [86:0] act, input logic [86:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic res_t model(input bit sub, input logic [1:0] rm,
                                   input logic [2:0] ac, input bit as_, input logic [15:0] ae, input logic [63:0] am,
                                   input logic [2:0] bc, input bit bs_, input logic [15:0] be, input logic [63:0] bm,
                                   output string tag);
        res_t r;
        logic [2:0] xc, yc, tc;
        bit xs, ys, ts, stk;
        int xe, ye, te, d;
        logic [63:0] xm, ym, tm, t;
        r = '0;
        tag = sub ? "R1" : "";
        xc = ac; xs = as_;       xe = int'($signed(ae)); xm = am;
        yc = bc; ys = bs_ ^ sub; ye = int'($signed(be)); ym = bm;
        if (xc > yc) begin
            tag = {tag, " R2"};
            tc = xc; ts = xs; te = xe; tm = xm;
            xc = yc; xs = ys; xe = ye; xm = ym;
            yc = tc; ys = ts; ye = te; ym = tm;
        end
        if (yc >= 3'd3) begin
            r.c = yc; r.s = ys; r.e = 16'(ye); r.m = ym; r.fn = 1'b1;
            tag = {tag, " R3"}; return r;
        end
        if (yc == 3'd2) begin
            tag = {tag, " R4"};
            if (xc == 3'd2 && xs != ys) begin
                r.c = 3'd3; r.s = 1'b0; r.e = '0; r.m = DNAN; r.fi = 1'b1;
            end else begin
                r.c = yc; r.s = ys; r.e = 16'(ye); r.m = ym;
            end
            return r;
        end
        if (yc == 3'd0 || xc == 3'd0) begin
            tag = {tag, " R5"};
            r.c = yc; r.e = 16'(ye); r.m = ym;
            if (yc == 3'd0) r.s = (rm == 2'd3) ? (xs | ys) : (xs & ys);
            else            r.s = ys;
            return r;
        end
        if (xe < ye) begin
            tc = xc; ts = xs; te = xe; tm = xm;
            xc = yc; xs = ys; xe = ye; xm = ym;
            yc = tc; ys = ts; ye = te; ym = tm;
        end
        d = xe - ye;
        stk = 1'b0;
        if (d > 0) tag = {tag, " R6"};
        if (d >= 64) begin
            stk = |ym; ym = '0;
        end else begin
            for (int i = 0; i < d; i++) begin
                stk = stk | ym[0];
                ym = ym >> 1;
            end
        end
        r.c = 3'd1;
        if (xs == ys) begin
            tag = {tag, " R7"};
            t = xm + ym;
            te = xe;
            if (t[63]) begin
                stk = stk | t[0];
                t = t >> 1;
                te = te + 1;
            end
            r.s = xs; r.e = 16'(te); r.m = t; r.k = stk;
            return r;
        end
        t = xm - ym - {63'b0, stk};
        if (t == '0) begin
            tag = {tag, " R9"};
            r.c = 3'd0; r.s = (rm == 2'd3); r.e = '0; r.m = '0; r.k = 1'b0;
            return r;
        end
        tag = {tag, " R8"};
        r.s = xs;
        if (t[63]) begin
            t = -t; r.s = ys;
        end
        te = xe;
        if (!t[62]) tag = {tag, " R10"};
        while (!t[62]) begin
            t = t << 1;
            te = te - 1;
        end
        r.e = 16'(te); r.m = t; r.k = stk;
        return r;
    endfunction

    task automatic run(input bit sub, input logic [1:0] rm,
                       input logic [2:0] ac, input bit as_, input logic [15:0] ae, input logic [63:0] am,
                       input logic [2:0] bc, input bit bs_, input logic [15:0] be, input logic [63:0] bm,
                       input bit hold);
        res_t e;
        string tag;
        int lat, want;
        e = model(sub, rm, ac, as_, ae, am, bc, bs_, be, bm, tag);
        want = (ac == 3'd1 && bc == 3'd1) ? 5 : 2;
        @(negedge clk);
        chk("R11 in_ready when idle", in_ready === 1'b1, 87'(in_ready), 87'(1));
        op_sub = sub; rnd_mode = rm;
        a_class = ac; a_sign = as_; a_exp = ae; a_mant = am;
        b_class = bc; b_sign = bs_; b_exp = be; b_mant = bm;
        out_ready = !hold;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        chk("R11 in_ready low while busy", in_ready === 1'b0, 87'(in_ready), 87'(0));
        while (out_valid !== 1'b1 && lat < 30) begin
            @(negedge clk);
            lat++;
        end
        chk({"R12 latency", tag}, lat == want, 87'(lat), 87'(want));
        chk({"result", tag}, got === e, got, e);
        if (hold) begin
            repeat (3) begin
                @(negedge clk);
                chk("R11 held result", out_valid === 1'b1 && got === e, got, e);
            end
            out_ready = 1'b1;
            @(negedge clk);
            chk("R11 release", out_valid === 1'b0, 87'(out_valid), 87'(0));
        end
    endtask

    task automatic gen(output logic [2:0] c, output bit s, output logic [15:0] e, output logic [63:0] m);
        int pick;
        pick = $urandom_range(0, 19);
        s = 1'($urandom_range(0, 1));
        c = 3'd1; e = 16'($urandom_range(0, 80) - 40);
        m = {2'b01, 62'({$urandom(), $urandom()})};
        if (pick == 0)      begin c = 3'd0; e = '0; m = '0; end
        else if (pick == 1) begin c = 3'd2; e = '0; m = '0; end
        else if (pick == 2) begin c = 3'd3; e = '0; end
        else if (pick == 3) begin c = 3'd4; e = '0; end
        else if (pick == 4) e = 16'($urandom_range(0, 400) - 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] ac, bc;
        bit as_, bs_;
        logic [15:0] ae, be;
        logic [63:0] am, bm;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", out_valid === 1'b0, 87'(out_valid), 87'(0));
        chk("R11 reset in_ready", in_ready === 1'b1, 87'(in_ready), 87'(1));
        rst_n = 1'b1;

        // R7 carry out: 1.0 + 1.0
        run(0, 2'd0, 3'd1, 0, 16'd3, ONE, 3'd1, 0, 16'd3, ONE, 0);
        // R9 exact cancellation, both zero signs
        run(1, 2'd0, 3'd1, 0, 16'd5, ONE, 3'd1, 0, 16'd5, ONE, 0);
        run(1, 2'd3, 3'd1, 1, 16'd5, ONE, 3'd1, 1, 16'd5, ONE, 0);
        // R8 borrow overflow with equal exponents, then R10
        run(0, 2'd0, 3'd1, 0, 16'd0, ONE, 3'd1, 1, 16'd0, ONE | (ONE >> 1), 0);
        // R6 shifts of 63, 64, 65 with sticky
        run(0, 2'd0, 3'd1, 0, 16'd63, ONE, 3'd1, 0, 16'd0, ONE | 64'd1, 0);
        run(0, 2'd0, 3'd1, 0, 16'd64, ONE, 3'd1, 1, 16'd0, ONE | 64'd1, 0);
        run(1, 2'd0, 3'd1, 0, 16'd0, ONE, 3'd1, 0, 16'hFFBF, ONE, 0);
        // R10 deep normalization
        run(1, 2'd0, 3'd1, 0, 16'd0, ONE, 3'd1, 0, 16'hFFFF, 64'h7FFF_FFFF_FFFF_FFFE, 0);
        // R4 infinities
        run(0, 2'd0, 3'd2, 0, 16'd0, 64'd0, 3'd2, 1, 16'd0, 64'd0, 0);
        run(1, 2'd0, 3'd2, 1, 16'd0, 64'd0, 3'd2, 1, 16'd0, 64'd0, 1);
        run(1, 2'd0, 3'd2, 0, 16'd0, 64'd0, 3'd2, 1, 16'd0, 64'd0, 0);
        run(0, 2'd0, 3'd1, 0, 16'd9, ONE, 3'd2, 1, 16'd0, 64'd0, 0);
        // R2 / R3 NaN ranking
        run(0, 2'd0, 3'd4, 1, 16'd0, ONE | 64'd7, 3'd3, 0, 16'd0, ONE | 64'd9, 0);
        run(1, 2'd0, 3'd3, 0, 16'd0, ONE | 64'd5, 3'd3, 0, 16'd0, ONE | 64'd6, 0);
        run(0, 2'd0, 3'd2, 0, 16'd0, 64'd0, 3'd4, 0, 16'd0, ONE, 0);
        // R5 zeros under each sign rule
        for (int rm = 0; rm < 4; rm++) begin
            run(0, 2'(rm), 3'd0, 0, 16'd0, 64'd0, 3'd0, 1, 16'd0, 64'd0, 0);
            run(0, 2'(rm), 3'd0, 1, 16'd0, 64'd0, 3'd0, 1, 16'd0, 64'd0, 0);
            run(1, 2'(rm), 3'd0, 0, 16'd0, 64'd0, 3'd0, 0, 16'd0, 64'd0, 0);
        end
        run(0, 2'd0, 3'd0, 1, 16'd0, 64'd0, 3'd1, 1, 16'd7, ONE | 64'd3, 0);
        run(1, 2'd3, 3'd1, 0, 16'd7, ONE | 64'd3, 3'd0, 0, 16'd0, 64'd0, 1);

        for (int n = 0; n < 600; n++) begin
            gen(ac, as_, ae, am);
            gen(bc, bs_, be, bm);
            if ($urandom_range(0, 2) == 0) be = ae;
            if ($urandom_range(0, 9) == 0) bm = am;
            run(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                ac, as_, ae, am, bc, bs_, be, bm, (n % 7) == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule